// File: doc/BRIEF.md
# Iterative Carry-Resolving Adder

This block adds two unsigned 32-bit operands by repeating one carry step, not by a ripple or lookahead chain. Two working registers are loaded with the operands. On each clock the block replaces one register with the bitwise XOR of the pair. It replaces the other with the bitwise AND of the pair shifted one place towards the most significant bit. The step repeats until the carry register holds zero. The remaining register then holds the sum. Any carry pushed past bit 31 is lost, so the result wraps modulo 2^32.

The latency depends on the data. It equals the number of carry steps the operand pair needs, plus one cycle to detect the empty carry word. A caller waits for `ready_o`, pulses `start_i` with the operands, and takes the result when `done_o` pulses. `steps_o` reports how many carry steps were used. A pair with a zero second operand takes no steps. Adding 1 to all-ones takes the maximum of 32 steps.

Top module: `iter_adder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters idle, with `ready_o`=1, `done_o`=0, `sum_o`=0 and `steps_o`=0.
- R2: For an accepted start with operands A (`lhs_i`) and B (`rhs_i`), the value shown on `sum_o` with `done_o` is (A+B) mod 2^32, and any carry out of bit 31 is lost.
- R3: A step sets the first working register to x XOR y and the carry register to (x AND y) shifted left by one. A step therefore keeps x+y mod 2^32 unchanged.
- R4: Let N be the number of steps taken until the carry register reads zero. Then `steps_o` equals N when `done_o` is high, and `done_o` rises N+1 clock edges after the edge that accepted the start.
- R5: If B is zero, the result is A, `steps_o` is 0, and `done_o` rises on the first edge after the accepting edge.
- R6: The worst case is 32 steps, for 0xFFFFFFFF plus 1 (result 0). `steps_o` never exceeds 32.
- R7: A `start_i` pulse while busy is ignored. The running computation and its result are unchanged, and no operands are captured.
- R8: `done_o` is high for exactly one cycle. `sum_o` and `steps_o` then hold their values until the next accepted start.
- R9: `ready_o` falls on the edge that accepts a start, stays low while busy, and is high again in the cycle in which `done_o` is high. Operands are sampled only on the accepting edge.
- R10: Adding 2 and 6 passes through the state carry=4, partial=4 and ends at 8 after 3 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to add; taken only while `ready_o` is high |
| lhs_i | input | 32 | First operand |
| rhs_i | input | 32 | Second operand, loaded into the carry register |
| ready_o | output | 1 | Idle and able to accept a start |
| done_o | output | 1 | One-cycle strobe marking a valid result |
| sum_o | output | 32 | Sum modulo 2^32, held until the next start |
| steps_o | output | 6 | Number of carry steps taken |

## Verification
Some properties are checked on every cycle. A step keeps the register sum unchanged, a start raised while busy never resets the step count, `done_o` lasts one cycle, the result holds between strobes, `ready_o` drops on acceptance, and the step count stays at or below 32. Only the bench scenarios can show the rest. These are the final sum for a given operand pair, the exact step count and latency, the operands being captured only at acceptance, and the named corner pairs: 0xFFFFFFFF+1, 2+6, and a zero second operand.

// File: rtl/iter_adder_pkg.sv
// Package: shared types and constants for the iterative adder.
// Assumes: one controller state type shared by the controller and the top.
package iter_adder_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_t;

endpackage

// File: rtl/iter_adder_step.sv
// Module: iter_adder_step
// Does: one combinational carry step on the pair (x, y). It gives x^y, the
//       AND word shifted up by one bit, and a flag for an empty carry word.
// Assumes: y is the carry register. The shifted-out top bit is dropped.
module iter_adder_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] part_o,
    output logic [W-1:0] carry_o,
    output logic         carry_zero_o
);

    // Per-bit half-adder slices: partial sum bit and carry into the next bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign part_o[i] = x_i[i] ^ y_i[i];
        if (i == 0) begin : g_lsb
            assign carry_o[i] = 1'b0;
        end else begin : g_upper
            assign carry_o[i] = x_i[i-1] & y_i[i-1];
        end
    end

    // Termination flag: no carries left to resolve.
    assign carry_zero_o = ~|y_i;

endmodule

// File: rtl/iter_adder_count.sv
// Module: iter_adder_count
// Does: counts carry steps. It clears on a new job, increments per step and
//       holds otherwise.
// Assumes: at most MAX steps per job, so the count never wraps.
module iter_adder_count #(
    parameter int MAX = 32,
    parameter int CW  = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          inc_i,
    output logic [CW-1:0] count_o
);

    // Step counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clear_i) begin
            count_o <= '0;
        end else if (inc_i) begin
            count_o <= count_o + 1'b1;
        end
    end

    // R6: the step count never goes past the worst case.
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(MAX));

endmodule

// File: rtl/iter_adder_ctrl.sv
// Module: iter_adder_ctrl
// Does: idle/busy sequencing. It accepts a start only when idle, steps
//       while carries remain, and finishes when the carry word is empty.
// Assumes: carry_zero_i reflects the carry register of the current cycle.
module iter_adder_ctrl
    import iter_adder_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic carry_zero_i,
    output logic load_o,
    output logic step_o,
    output logic finish_o,
    output logic ready_o
);

    phase_t phase_q;

    // Decode strobes for the datapath from the phase and carry flag.
    always_comb begin
        load_o   = (phase_q == PH_IDLE) && start_i;
        step_o   = (phase_q == PH_BUSY) && !carry_zero_i;
        finish_o = (phase_q == PH_BUSY) && carry_zero_i;
    end

    // Phase register: idle -> busy on accept, busy -> idle on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (load_o) begin
            phase_q <= PH_BUSY;
        end else if (finish_o) begin
            phase_q <= PH_IDLE;
        end
    end

    assign ready_o = (phase_q == PH_IDLE);

    // R9: an accepted start takes the block out of idle on the next cycle.
    a_r9_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> !ready_o);

    // R9: a busy block stays busy while carries remain.
    a_r9_busy_while_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !carry_zero_i) |=> !ready_o);

endmodule

// File: rtl/iter_adder.sv
// Module: iter_adder (top)
// Does: adds lhs_i + rhs_i modulo 2^W by repeated XOR/AND carry steps, with
//       a start/ready handshake, a one-cycle done strobe and a step count.
// Assumes: operands are valid in the cycle where start_i meets ready_o.
module iter_adder #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  lhs_i,
    input  logic [W-1:0]  rhs_i,
    output logic          ready_o,
    output logic          done_o,
    output logic [W-1:0]  sum_o,
    output logic [CW-1:0] steps_o
);

    logic [W-1:0] x_q, y_q;
    logic [W-1:0] part_w, carry_w;
    logic         carry_zero_w;
    logic         load_w, step_w, finish_w;
    logic [W-1:0] pair_total_w;

    iter_adder_step #(.W(W)) u_step (
        .x_i          (x_q),
        .y_i          (y_q),
        .part_o       (part_w),
        .carry_o      (carry_w),
        .carry_zero_o (carry_zero_w)
    );

    iter_adder_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .carry_zero_i (carry_zero_w),
        .load_o       (load_w),
        .step_o       (step_w),
        .finish_o     (finish_w),
        .ready_o      (ready_o)
    );

    iter_adder_count #(.MAX(W), .CW(CW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_w),
        .inc_i   (step_w),
        .count_o (steps_o)
    );

    // Working registers: load operands on accept, take one carry step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (load_w) begin
            x_q <= lhs_i;
            y_q <= rhs_i;
        end else if (step_w) begin
            x_q <= part_w;
            y_q <= carry_w;
        end
    end

    // Result register and done strobe: capture x when the carry word empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= finish_w;
            if (finish_w) begin
                sum_o <= x_q;
            end
        end
    end

    assign pair_total_w = x_q + y_q;

    // R3: a carry step leaves the modular sum of the working pair unchanged.
    a_r3_sum_conserved: assert property (@(posedge clk) disable iff (!rst_n)
        step_w |=> pair_total_w == $past(pair_total_w));

    // R7: a start seen while busy never restarts the step count.
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && start_i) |=> steps_o >= $past(steps_o));

    // R8: the done strobe lasts exactly one cycle.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the result holds between strobes.
    a_r8_sum_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(sum_o));

    // R9: the block is idle again when the result is presented.
    a_r9_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ready_o);

endmodule

// File: tb/iter_adder_bench.sv
module iter_adder_bench;

    localparam int W  = 32;
    localparam int CW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [W-1:0]  lhs_i = '0;
    logic [W-1:0]  rhs_i = '0;
    logic          ready_o, done_o;
    logic [W-1:0]  sum_o;
    logic [CW-1:0] steps_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    iter_adder #(.W(W)) u_iter_adder (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .lhs_i   (lhs_i),
        .rhs_i   (rhs_i),
        .ready_o (ready_o),
        .done_o  (done_o),
        .sum_o   (sum_o),
        .steps_o (steps_o)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Step count worked out from the carry-step rule of R3, stopping when
    // the carry word is zero.
    function automatic int ref_steps(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] p = a;
        logic [W-1:0] c = b;
        logic [W-1:0] t;
        int n = 0;
        while (c != '0) begin
            t = (p & c) << 1;
            p = p ^ c;
            c = t;
            n++;
        end
        return n;
    endfunction

    // One addition: launch, optionally poke start while busy, wait for done.
    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        logic [W-1:0] exp_sum = a + b;
        int exp_n = ref_steps(a, b);
        int c = 0;
        @(negedge clk);
        lhs_i = a; rhs_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lhs_i = ~a; rhs_i = 32'h1357_9bdf;           // R9: later operand values are not sampled
        check("R9 ready low after accept", ready_o, 0);
        if (poke) begin
            start_i = 1'b1;                           // R7: start while busy
        end
        while (!done_o && c < 100) begin
            @(negedge clk);
            start_i = 1'b0;
            c++;
        end
        check("R4 latency", c, exp_n + 1);
        check("R2 sum", sum_o, exp_sum);
        check("R4 steps", steps_o, exp_n);
        check("R9 ready with done", ready_o, 1);
        @(negedge clk);
        check("R8 done one cycle", done_o, 0);
        check("R8 sum held", sum_o, exp_sum);
        check("R8 steps held", steps_o, exp_n);
        if (poke) begin
            check("R7 no restart after busy start", ready_o, 1);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 ready", ready_o, 1);
        check("R1 done", done_o, 0);
        check("R1 sum", sum_o, 0);
        check("R1 steps", steps_o, 0);
        rst_n = 1'b1;

        run_add(32'd2, 32'd6, 1'b0);                   // R10: 2+6 -> 8 in 3 steps
        check("R10 steps for 2+6", steps_o, 3);
        run_add(32'hFFFF_FFFF, 32'd1, 1'b0);           // R6 worst case, wraps to 0
        check("R6 worst-case steps", steps_o, 32);
        check("R6 wrapped sum", sum_o, 0);
        run_add(32'hDEAD_BEEF, 32'd0, 1'b0);           // R5 zero carry operand
        check("R5 zero steps", steps_o, 0);
        run_add(32'd0, 32'h8000_0001, 1'b0);           // R5 counter-case: lhs zero still steps
        run_add(32'h8000_0000, 32'h8000_0000, 1'b0);   // R2 carry out of bit 31 dropped
        check("R2 top carry dropped", sum_o, 0);
        run_add(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1);   // R7 start while busy on a long job
        run_add(32'd5, 32'd0, 1'b1);                   // R7 start during detect cycle

        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] a = $urandom;
            logic [W-1:0] b = $urandom;
            case (i % 4)
                1: b = b & 32'h0000_00FF;
                2: a = ~b ^ (32'd1 << (i % 32));
                3: a = 32'hFFFF_FFFF;
                default: ;
            endcase
            run_add(a, b, (i % 5) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule